// File: doc/BRIEF.md
# Double-Buffered Channel Setting Register Bank

This block is the register file that sits between a byte-wide bus write port and an eighteen-channel PWM engine. Each channel owns an 8-bit duty value and a 6-bit current-select code. Both are written first into a shadow copy. The engine keeps using the previous settings until software writes zero to the commit address. At that point every shadow value moves into the live copy on the same clock edge, so all channels change together with no partly updated frame.

Three single-bit controls take effect as soon as they are written: a run flag (0 stops the outputs and 1 lets them run), a blanking flag that forces every channel off, and a PWM rate select. A write of zero to the clear address returns every register to zero, both shadow and live, in one clock. Stopping the outputs with the run flag leaves all stored values in place. The address map follows from the channel count. Address 00h holds the run flag. The duty registers start at 01h, the commit address comes right after them, then the select registers, then the blanking and rate registers. The clear address is a parameter and defaults to 2Fh.

Top module: `chan_regbank`

## Requirements
- R1: While `rst` is high, every output goes to zero one clock later. After reset, all duty and select outputs and all three control flags read 0.
- R2: A write to address 01h+k (k = 0..17) stores `wr_data[7:0]` in the shadow duty register of channel k. `duty_flat[k*8 +: 8]` does not change until a commit.
- R3: A write to address 14h+k stores `wr_data[5:0]` in the shadow select register of channel k, and `wr_data[7:6]` is dropped. `sel_flat[k*6 +: 6]` does not change until a commit.
- R4: A write of 00h to address 13h copies every shadow duty and select value to the outputs on the edge that samples the write.
- R5: A write of any nonzero value to address 13h has no effect.
- R6: A write to address 00h sets `run` to `wr_data[0]` on the same edge, and bits 7:1 are ignored.
- R7: A write to address 26h sets `blank` to `wr_data[0]`, and a write to address 27h sets `rate_sel` to `wr_data[0]`. Both take effect on the same edge.
- R8: A write of 00h to address 2Fh clears every shadow register, every live register and every control flag on one edge. A later commit then outputs zeros.
- R9: A write of any nonzero value to address 2Fh has no effect.
- R10: Writes to unmapped addresses (28h..2Eh and 30h..FFh) change no output and no shadow value.
- R11: Setting `run` to 0 and back to 1 leaves all live and shadow contents unchanged.
- R12: With `wr_en` low, no address or data value changes anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| duty_flat | output | 144 | Live duty values, channel k at bits k*8 +: 8 |
| sel_flat | output | 108 | Live current-select codes, channel k at bits k*6 +: 6 |
| run | output | 1 | 1 = outputs running, 0 = stopped |
| blank | output | 1 | 1 = all channels forced off |
| rate_sel | output | 1 | PWM rate select |

## Verification
Every result lands on the clock edge that samples the write, because the outputs are the registers themselves. The bench drives each write on a falling edge and reads the outputs at the next falling edge, one full cycle later and half a cycle after that update. Shadow-only effects are not visible on the ports. The bench therefore confirms each one with a commit and then samples one cycle after that commit. The soft clear is confirmed the same way: a commit issued after the clear must output zeros.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              run_wr;
    logic              blank_wr;
    logic              rate_wr;
    logic              commit;
    logic              clear;
    logic              duty_wr;
    logic              sel_wr;
    logic [ADDR_W-1:0] idx;
  } wr_dec_t;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int NCH         = 18,
  parameter int DUTY_BASE   = 1,
  parameter int COMMIT_ADDR = 19,
  parameter int SEL_BASE    = 20,
  parameter int BLANK_ADDR  = 38,
  parameter int RATE_ADDR   = 39,
  parameter int CLEAR_ADDR  = 47
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wr_dec_t           dec
);
  logic [ADDR_W-1:0] off_duty, off_sel;
  logic              in_duty, in_sel, zero_data;

  always_comb begin
    off_duty  = wr_addr - ADDR_W'(DUTY_BASE);
    off_sel   = wr_addr - ADDR_W'(SEL_BASE);
    in_duty   = (wr_addr >= ADDR_W'(DUTY_BASE)) && (wr_addr < ADDR_W'(DUTY_BASE + NCH));
    in_sel    = (wr_addr >= ADDR_W'(SEL_BASE)) && (wr_addr < ADDR_W'(SEL_BASE + NCH));
    zero_data = (wr_data == '0);

    dec          = '0;
    dec.run_wr   = wr_en && (wr_addr == '0);
    dec.blank_wr = wr_en && (wr_addr == ADDR_W'(BLANK_ADDR));
    dec.rate_wr  = wr_en && (wr_addr == ADDR_W'(RATE_ADDR));
    dec.commit   = wr_en && (wr_addr == ADDR_W'(COMMIT_ADDR)) && zero_data;
    dec.clear    = wr_en && (wr_addr == ADDR_W'(CLEAR_ADDR)) && zero_data;
    dec.duty_wr  = wr_en && in_duty;
    dec.sel_wr   = wr_en && in_sel;
    dec.idx      = in_duty ? off_duty : (in_sel ? off_sel : '0);
  end
endmodule

// File: rtl/regbank_stage.sv
module regbank_stage
  import regbank_pkg::*;
#(
  parameter int NCH = 18,
  parameter int DW  = 8,
  parameter int SW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_dec_t           dec,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH*DW-1:0] duty_flat,
  output logic [NCH*SW-1:0] sel_flat
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] sh_duty, live_duty;
    logic [SW-1:0] sh_sel, live_sel;
    logic          hit;

    assign hit = (dec.idx == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst || dec.clear) begin
        sh_duty   <= '0;
        sh_sel    <= '0;
        live_duty <= '0;
        live_sel  <= '0;
      end else begin
        if (dec.duty_wr && hit) sh_duty <= wr_data[DW-1:0];
        if (dec.sel_wr && hit)  sh_sel  <= wr_data[SW-1:0];
        if (dec.commit) begin
          live_duty <= sh_duty;
          live_sel  <= sh_sel;
        end
      end
    end

    assign duty_flat[i*DW +: DW] = live_duty;
    assign sel_flat[i*SW +: SW]  = live_sel;
  end
endmodule

// File: rtl/regbank_ctl.sv
module regbank_ctl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wr_dec_t           dec,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run,
  output logic              blank,
  output logic              rate_sel
);
  always_ff @(posedge clk) begin
    if (rst || dec.clear) begin
      run      <= 1'b0;
      blank    <= 1'b0;
      rate_sel <= 1'b0;
    end else begin
      if (dec.run_wr)   run      <= wr_data[0];
      if (dec.blank_wr) blank    <= wr_data[0];
      if (dec.rate_wr)  rate_sel <= wr_data[0];
    end
  end
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
  import regbank_pkg::*;
#(
  parameter int NCH        = 18,
  parameter int DW         = 8,
  parameter int SW         = 6,
  parameter int CLEAR_ADDR = 47
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NCH*DW-1:0] duty_flat,
  output logic [NCH*SW-1:0] sel_flat,
  output logic              run,
  output logic              blank,
  output logic              rate_sel
);
  localparam int DUTY_BASE   = 1;
  localparam int COMMIT_ADDR = DUTY_BASE + NCH;
  localparam int SEL_BASE    = COMMIT_ADDR + 1;
  localparam int BLANK_ADDR  = SEL_BASE + NCH;
  localparam int RATE_ADDR   = BLANK_ADDR + 1;

  wr_dec_t dec;

  regbank_decode #(
    .NCH(NCH), .DUTY_BASE(DUTY_BASE), .COMMIT_ADDR(COMMIT_ADDR),
    .SEL_BASE(SEL_BASE), .BLANK_ADDR(BLANK_ADDR), .RATE_ADDR(RATE_ADDR),
    .CLEAR_ADDR(CLEAR_ADDR)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dec(dec)
  );

  regbank_stage #(.NCH(NCH), .DW(DW), .SW(SW)) u_stage (
    .clk(clk), .rst(rst), .dec(dec), .wr_data(wr_data),
    .duty_flat(duty_flat), .sel_flat(sel_flat)
  );

  regbank_ctl u_ctl (
    .clk(clk), .rst(rst), .dec(dec), .wr_data(wr_data),
    .run(run), .blank(blank), .rate_sel(rate_sel)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
  parameter int NCH        = 18,
  parameter int DW         = 8,
  parameter int SW         = 6,
  parameter int CLEAR_ADDR = 47
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [NCH*DW-1:0] duty_flat,
  input logic [NCH*SW-1:0] sel_flat,
  input logic              run,
  input logic              blank,
  input logic              rate_sel
);
  localparam logic [7:0] A_COMMIT = 8'(NCH + 1);
  localparam logic [7:0] A_BLANK  = 8'(2 * NCH + 2);
  localparam logic [7:0] A_RATE   = 8'(2 * NCH + 3);
  localparam logic [7:0] A_CLEAR  = 8'(CLEAR_ADDR);

  logic live_wr, ctl_wr;
  assign live_wr = wr_en && (wr_addr == A_COMMIT || wr_addr == A_CLEAR);
  assign ctl_wr  = wr_en && (wr_addr == 8'h00 || wr_addr == A_BLANK ||
                             wr_addr == A_RATE || wr_addr == A_CLEAR);

  // R1
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (duty_flat == '0 && sel_flat == '0 && !run && !blank && !rate_sel));

  // R2, R3
  p_live_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !live_wr |=> ($stable(duty_flat) && $stable(sel_flat)));

  // R8
  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CLEAR && wr_data == 8'h00) |=>
      (duty_flat == '0 && sel_flat == '0 && !run && !blank && !rate_sel));

  // R6
  p_run_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h00) |=> (run == $past(wr_data[0])));

  // R7
  p_blank_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_BLANK) |=> (blank == $past(wr_data[0])));

  // R10, R12
  p_ctl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> ($stable(run) && $stable(blank) && $stable(rate_sel)));
endmodule

bind chan_regbank regbank_chk #(
  .NCH(NCH), .DW(DW), .SW(SW), .CLEAR_ADDR(CLEAR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .duty_flat(duty_flat), .sel_flat(sel_flat), .run(run), .blank(blank),
  .rate_sel(rate_sel)
);

// File: tb/chan_regbank_bench.sv
module chan_regbank_bench;
  localparam int NCH = 18;
  localparam int DW  = 8;
  localparam int SW  = 6;
  localparam int NV  = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [NCH*DW-1:0] duty_flat;
  logic [NCH*SW-1:0] sel_flat;
  logic              run, blank, rate_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chan_regbank u_chan_regbank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_flat(duty_flat), .sel_flat(sel_flat), .run(run), .blank(blank),
    .rate_sel(rate_sel)
  );

  // {addr, data, channel to check, expected duty, expected select, expected {run,blank,rate}, req}
  localparam logic [41:0] VEC [NV] = '{
    {8'h01, 8'h5A, 5'd0,  8'h00, 6'h00, 3'b000, 4'd2},  // R2 staged only
    {8'h12, 8'hC3, 5'd17, 8'h00, 6'h00, 3'b000, 4'd2},  // R2 last channel
    {8'h14, 8'hFF, 5'd0,  8'h00, 6'h00, 3'b000, 4'd3},  // R3 staged only
    {8'h25, 8'h11, 5'd17, 8'h00, 6'h00, 3'b000, 4'd3},  // R3 last channel
    {8'h13, 8'h01, 5'd0,  8'h00, 6'h00, 3'b000, 4'd5},  // R5 nonzero commit
    {8'h13, 8'h00, 5'd0,  8'h5A, 6'h3F, 3'b000, 4'd4},  // R4 commit, R3 top bits dropped
    {8'h13, 8'h00, 5'd17, 8'hC3, 6'h11, 3'b000, 4'd4},  // R4 other channel
    {8'h00, 8'hFE, 5'd0,  8'h5A, 6'h3F, 3'b000, 4'd6},  // R6 upper bits ignored
    {8'h00, 8'h01, 5'd0,  8'h5A, 6'h3F, 3'b100, 4'd6},  // R6 run set
    {8'h26, 8'h03, 5'd0,  8'h5A, 6'h3F, 3'b110, 4'd7},  // R7 blank
    {8'h27, 8'hFF, 5'd0,  8'h5A, 6'h3F, 3'b111, 4'd7},  // R7 rate
    {8'h2A, 8'hFF, 5'd0,  8'h5A, 6'h3F, 3'b111, 4'd10}, // R10 unmapped
    {8'h2F, 8'h80, 5'd0,  8'h5A, 6'h3F, 3'b111, 4'd9},  // R9 nonzero clear
    {8'h01, 8'h10, 5'd0,  8'h5A, 6'h3F, 3'b111, 4'd2},  // R2 new staged value
    {8'h00, 8'h00, 5'd0,  8'h5A, 6'h3F, 3'b011, 4'd11}, // R11 stop keeps contents
    {8'h00, 8'h01, 5'd0,  8'h5A, 6'h3F, 3'b111, 4'd11}, // R11 restart
    {8'h13, 8'h00, 5'd0,  8'h10, 6'h3F, 3'b111, 4'd11}, // R11 shadow survived stop
    {8'h2F, 8'h00, 5'd17, 8'h00, 6'h00, 3'b000, 4'd8},  // R8 clear
    {8'h13, 8'h00, 5'd0,  8'h00, 6'h00, 3'b000, 4'd8},  // R8 shadow cleared too
    {8'hFF, 8'hFF, 5'd0,  8'h00, 6'h00, 3'b000, 4'd10}  // R10 top address
  };

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input int req, input int ch, input logic [7:0] ed,
                     input logic [5:0] es, input logic [2:0] ec);
    logic [7:0] ad;
    logic [5:0] as;
    logic [2:0] ac;
    ad = duty_flat[ch*DW +: DW];
    as = sel_flat[ch*SW +: SW];
    ac = {run, blank, rate_sel};
    checks++;
    if (ad !== ed || as !== es || ac !== ec) begin
      failures++;
      $display("FAIL R%0d ch%0d duty=%h/%h sel=%h/%h ctl=%b/%b (actual/expected)",
               req, ch, ad, ed, as, es, ac, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state on every channel
    for (int c = 0; c < NCH; c++) chk(1, c, 8'h00, 6'h00, 3'b000);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][41:34], VEC[v][33:26]);
      chk(int'(VEC[v][3:0]), int'(VEC[v][25:21]), VEC[v][20:13], VEC[v][12:7], VEC[v][6:4]);
    end

    // R12: strobe low, run write and commit must do nothing
    wr(8'h01, 8'h77);
    @(negedge clk);
    wr_addr = 8'h00; wr_data = 8'h01;
    @(negedge clk);
    chk(12, 0, 8'h00, 6'h00, 3'b000);
    wr_addr = 8'h13; wr_data = 8'h00;
    @(negedge clk);
    chk(12, 0, 8'h00, 6'h00, 3'b000);
    wr(8'h13, 8'h00);
    chk(4, 0, 8'h77, 6'h00, 3'b000);

    // R10: write to address between rate and clear does not touch shadow
    wr(8'h2E, 8'h55);
    wr(8'h13, 8'h00);
    chk(10, 0, 8'h77, 6'h00, 3'b000);

    // R1: hardware reset mid-run clears all
    wr(8'h26, 8'h01);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(1, 0, 8'h00, 6'h00, 3'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule